// File: doc/BRIEF.md
# Scan Test Sequencer with Shared-Pin Scan Chain

This block wraps a small state machine whose N-bit state register is turned into a scan chain by a multiplexer in front of every flip-flop. Each flip-flop can hold, take its functional next-state value, or take the value of its upstream neighbour. In functional operation (`test_en` low), the machine runs freely from the primary input pin, and the primary output pin shows the parity of the state. Raising `test_en` hands both pins to the test path. The input pin then serves as scan-in during the integrity check, and the output pin shows the scan-out flop.

A sequencer runs the complete scan session by itself. It first checks the chain with a flush. The tester drives a period-four sequence 0,0,1,1 on the shared input pin for 2N cycles. From the N-th cycle on, the sequencer compares the chain tail against the bit sent N cycles earlier. A mismatch raises a sticky error and halts the session. When the flush passes, stimulus words arrive on a valid/ready stream. Each word is shifted in over N cycles and followed by exactly one functional capture clock. The captured state is shifted out one bit per cycle, with a valid strobe, while the next word shifts in. A word marked last ends the session: after its capture, N further shifts unload its response.

Top module: `scan_test_ctrl`

## Requirements
- R1: While reset is asserted and just after its release, `chain_err`, `test_done`, `pat_ready` and `rsp_valid` are 0, and every state flop is 0, so `pin_out` reads 0 in functional operation.
- R2: With `test_en` low, the state s updates on every clock. Let fb = s[N-1] xor `pin_in`. The new state is {s[N-2:0],0} xor (fb ? POLY : 0), with POLY = 0x1D for N=8. `pin_out` is the XOR of all state bits.
- R3: With `test_en` high, `pin_out` carries the scan-out flop, state bit 0. Whenever `rsp_valid` is 1, `rsp_bit` equals `pin_out`.
- R4: After `test_en` is seen high in the idle state, one hold cycle follows, then 2N flush shift cycles. In flush cycle k, scan-in is taken from `pin_in`. For k ≥ N, the tail must equal bit 1 of (k−N). `pat_ready` and `rsp_valid` stay 0 during the flush.
- R5: A flush mismatch sets `chain_err`. The flag stays set, even after `test_en` falls, until the next session starts. While the flag is set, no word is accepted and `test_done` stays 0.
- R6: A word is accepted in a cycle with `pat_valid` and `pat_ready` both high. It is shifted in bit 0 first over N cycles. Exactly one functional clock follows, and that clock uses `pin_in` as the primary input.
- R7: The captured state leaves bit 0 first, one bit per `rsp_valid` strobe. For every word except the last, this happens during the load of the next word. The first word's load therefore produces no response bits, and N·(i−1) bits have been emitted when word i ≥ 1 is accepted.
- R8: While the sequencer waits for a word, the chain holds its contents, so `pin_out` stays at the captured bit 0.
- R9: After the capture of a word sent with `pat_last` high, N unload shifts follow, with `rsp_last` on the final bit. `test_done` is then 1 until `test_en` falls, and 0 in the cycle after.
- R10: After `test_en` falls, functional operation per R2 resumes from the chain contents. These are all zero after a completed session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test session enable; also selects the function of the shared pins |
| pin_in | input | 1 | Shared pin: functional input, flush scan-in, capture primary input |
| pin_out | output | 1 | Shared pin: state parity in functional use, scan-out in test |
| pat_valid | input | 1 | Stimulus word valid |
| pat_ready | output | 1 | Sequencer can take a stimulus word |
| pat_data | input | N | Stimulus word, bit 0 ends nearest scan-out |
| pat_last | input | 1 | Marks the final stimulus word |
| rsp_valid | output | 1 | Response bit valid strobe |
| rsp_bit | output | 1 | Response bit, flop nearest scan-out first |
| rsp_last | output | 1 | Final response bit of the session |
| chain_err | output | 1 | Sticky flush mismatch flag |
| test_done | output | 1 | Session completed |

## Verification
The hardest situation to reach from the ports is a failing flush. With a healthy chain, the tail always reproduces what entered N cycles earlier. The bench reaches the error path by driving one wrong bit on the shared input pin during the flush. The tail then disagrees with the sequence the sequencer expects N cycles later. The bench checks that the error appears, that it blocks stimulus, that it survives `test_en` falling, and that it is cleared by the next session. A stall between stimulus words is also forced, to show that the held chain keeps the captured state visible on the output pin.

// File: rtl/scan_test_pkg.sv
package scan_test_pkg;

    typedef enum logic [1:0] {
        MD_HOLD,
        MD_SHIFT,
        MD_FUNC
    } chain_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FLUSH,
        SQ_WAIT,
        SQ_SHIFT,
        SQ_CAPT,
        SQ_UNLOAD,
        SQ_DONE,
        SQ_HALT
    } seq_state_e;

endpackage

// File: rtl/scan_chain_reg.sv
module scan_chain_reg
    import scan_test_pkg::*;
#(
    parameter int N = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  chain_mode_e mode,
    input  logic        scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic shift_d;
        logic cell_q;

        if (i == N - 1) begin : g_head
            assign shift_d = scan_in;
        end else begin : g_link
            assign shift_d = q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else begin
                unique case (mode)
                    MD_SHIFT: cell_q <= shift_d;
                    MD_FUNC:  cell_q <= func_d[i];
                    default:  cell_q <= cell_q;
                endcase
            end
        end

        assign q[i] = cell_q;
    end

endmodule

// File: rtl/scan_core_logic.sv
module scan_core_logic #(
    parameter int           N    = 8,
    parameter logic [N-1:0] POLY = N'(29)
) (
    input  logic [N-1:0] q,
    input  logic         pin_in,
    output logic [N-1:0] func_d,
    output logic         func_out
);

    logic fb;

    assign fb       = q[N-1] ^ pin_in;
    assign func_d   = {q[N-2:0], 1'b0} ^ ({N{fb}} & POLY);
    assign func_out = ^q;

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_test_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         pin_in,
    input  logic         scan_out,
    input  logic         pat_valid,
    input  logic [N-1:0] pat_data,
    input  logic         pat_last,
    output logic         pat_ready,
    output chain_mode_e  mode,
    output logic         scan_in,
    output logic         rsp_valid,
    output logic         rsp_last,
    output logic         chain_err,
    output logic         test_done,
    output seq_state_e   st
);

    localparam int            CW        = $clog2(2 * N) + 1;
    localparam logic [CW-1:0] FLUSH_END = CW'(2 * N - 1);
    localparam logic [CW-1:0] LOAD_END  = CW'(N - 1);
    localparam logic [CW-1:0] FILL_LEN  = CW'(N);

    seq_state_e    st_nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] ref_idx;
    logic [N-1:0]  sr;
    logic          last_q;
    logic          have_rsp;
    logic          err_q;
    logic          flush_bad;
    logic          accept;
    logic          start;

    // flush reference: the 0,0,1,1 sequence sent N cycles earlier
    assign ref_idx   = cnt - FILL_LEN;
    assign flush_bad = (st == SQ_FLUSH) && test_en && (cnt >= FILL_LEN)
                       && (scan_out != ref_idx[1]);
    assign accept    = pat_valid && pat_ready;
    assign start     = (st == SQ_IDLE) && test_en;

    // transitions
    always_comb begin
        st_nxt = st;
        if (st == SQ_IDLE) begin
            if (test_en) st_nxt = SQ_FLUSH;
        end else if (!test_en) begin
            st_nxt = SQ_IDLE;
        end else begin
            unique case (st)
                SQ_FLUSH: begin
                    if (flush_bad)             st_nxt = SQ_HALT;
                    else if (cnt == FLUSH_END) st_nxt = SQ_WAIT;
                end
                SQ_WAIT:   if (pat_valid) st_nxt = SQ_SHIFT;
                SQ_SHIFT:  if (cnt == LOAD_END) st_nxt = SQ_CAPT;
                SQ_CAPT:   st_nxt = last_q ? SQ_UNLOAD : SQ_WAIT;
                SQ_UNLOAD: if (cnt == LOAD_END) st_nxt = SQ_DONE;
                default:   st_nxt = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nxt;
    end

    // counters, stimulus serialiser and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sr       <= '0;
            last_q   <= 1'b0;
            have_rsp <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (st_nxt != st) cnt <= '0;
            else              cnt <= cnt + CW'(1);

            if (accept) begin
                sr     <= pat_data;
                last_q <= pat_last;
            end else if (st == SQ_SHIFT && test_en) begin
                sr <= sr >> 1;
            end

            if (start)                           have_rsp <= 1'b0;
            else if (st == SQ_CAPT && test_en)   have_rsp <= 1'b1;

            if (start)          err_q <= 1'b0;
            else if (flush_bad) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mode      = MD_HOLD;
        scan_in   = 1'b0;
        pat_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
        test_done = 1'b0;
        if (st == SQ_IDLE) begin
            mode = test_en ? MD_HOLD : MD_FUNC;
        end else if (test_en) begin
            unique case (st)
                SQ_FLUSH: begin
                    mode    = MD_SHIFT;
                    scan_in = pin_in;
                end
                SQ_WAIT:  pat_ready = 1'b1;
                SQ_SHIFT: begin
                    mode      = MD_SHIFT;
                    scan_in   = sr[0];
                    rsp_valid = have_rsp;
                end
                SQ_CAPT:  mode = MD_FUNC;
                SQ_UNLOAD: begin
                    mode      = MD_SHIFT;
                    rsp_valid = 1'b1;
                    rsp_last  = (cnt == LOAD_END);
                end
                SQ_DONE:  test_done = 1'b1;
                default:  mode = MD_HOLD;
            endcase
        end
    end

    assign chain_err = err_q;

endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl
    import scan_test_pkg::*;
#(
    parameter int           N    = 8,
    parameter logic [N-1:0] POLY = N'(29)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         pin_in,
    output logic         pin_out,
    input  logic         pat_valid,
    output logic         pat_ready,
    input  logic [N-1:0] pat_data,
    input  logic         pat_last,
    output logic         rsp_valid,
    output logic         rsp_bit,
    output logic         rsp_last,
    output logic         chain_err,
    output logic         test_done
);

    chain_mode_e  mode;
    seq_state_e   seq_st;
    logic         scan_in;
    logic [N-1:0] chain_q;
    logic [N-1:0] func_d;
    logic         func_out;

    scan_chain_reg #(.N(N)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .scan_in (scan_in),
        .func_d  (func_d),
        .q       (chain_q)
    );

    scan_core_logic #(.N(N), .POLY(POLY)) u_core (
        .q        (chain_q),
        .pin_in   (pin_in),
        .func_d   (func_d),
        .func_out (func_out)
    );

    scan_sequencer #(.N(N)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .pin_in    (pin_in),
        .scan_out  (chain_q[0]),
        .pat_valid (pat_valid),
        .pat_data  (pat_data),
        .pat_last  (pat_last),
        .pat_ready (pat_ready),
        .mode      (mode),
        .scan_in   (scan_in),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .chain_err (chain_err),
        .test_done (test_done),
        .st        (seq_st)
    );

    // shared output pin: scan-out in test, parity in functional use
    assign pin_out = test_en ? chain_q[0] : func_out;
    assign rsp_bit = chain_q[0];

endmodule

// File: rtl/scan_test_ctrl_chk.sv
module scan_test_ctrl_chk
    import scan_test_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_en,
    input logic         pin_out,
    input logic         pat_valid,
    input logic         pat_ready,
    input logic         rsp_valid,
    input logic         rsp_bit,
    input logic         rsp_last,
    input logic         chain_err,
    input logic         test_done,
    input seq_state_e   seq_st,
    input logic [N-1:0] chain_q
);

    assert_rsp_on_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_bit == pin_out));

    assert_flush_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_FLUSH) |-> (!pat_ready && !rsp_valid));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_err && !(seq_st == SQ_IDLE && test_en)) |=> chain_err);

    assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> (!pat_ready && !test_done));

    assert_accept_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && pat_ready) |=> !pat_ready);

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_WAIT && $past(seq_st) == SQ_WAIT) |-> (chain_q == $past(chain_q)));

    assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    assert_last_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> (test_done || !test_en));

endmodule

bind scan_test_ctrl scan_test_ctrl_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .pin_out   (pin_out),
    .pat_valid (pat_valid),
    .pat_ready (pat_ready),
    .rsp_valid (rsp_valid),
    .rsp_bit   (rsp_bit),
    .rsp_last  (rsp_last),
    .chain_err (chain_err),
    .test_done (test_done),
    .seq_st    (seq_st),
    .chain_q   (chain_q)
);

// File: tb/scan_test_ctrl_tb.sv
`timescale 1ns/1ps
module scan_test_ctrl_tb;

    localparam int         N    = 8;
    localparam logic [7:0] POLY = 8'h1D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_en = 1'b0;
    logic         pin_in = 1'b0;
    logic         pin_out;
    logic         pat_valid = 1'b0;
    logic         pat_ready;
    logic [N-1:0] pat_data = '0;
    logic         pat_last = 1'b0;
    logic         rsp_valid;
    logic         rsp_bit;
    logic         rsp_last;
    logic         chain_err;
    logic         test_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nbits = 0;
    int last_at = -1;
    bit rsp_bits [0:511];
    logic [N-1:0] pats [0:3];

    always #4 clk = ~clk;

    scan_test_ctrl #(.N(N), .POLY(POLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .pin_in(pin_in),
        .pin_out(pin_out), .pat_valid(pat_valid), .pat_ready(pat_ready),
        .pat_data(pat_data), .pat_last(pat_last), .rsp_valid(rsp_valid),
        .rsp_bit(rsp_bit), .rsp_last(rsp_last), .chain_err(chain_err),
        .test_done(test_done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_nxt(input logic [N-1:0] s, input logic b);
        logic fb;
        fb = s[N-1] ^ b;
        return {s[N-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    // response monitor: records strobed bits a little after each falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            check(rsp_bit == pin_out, "R3 rsp_bit on pin_out", rsp_bit, pin_out);
            rsp_bits[nbits] = rsp_bit;
            if (rsp_last) last_at = nbits;
            nbits++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // called right after a falling edge; returns right after one
    task automatic t_normal(input int cycles, input logic [N-1:0] start_m, input string tag);
        logic [N-1:0] m;
        logic b;
        m = start_m;
        for (int c = 0; c < cycles; c++) begin
            check(pin_out == ^m, tag, pin_out, ^m);
            b = ((c * 7 + 3) % 5) < 2;
            pin_in = b;
            @(posedge clk);
            m = model_nxt(m, b);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(chain_err == 1'b0, "R1 chain_err in reset", chain_err, 0);
        check(test_done == 1'b0, "R1 test_done in reset", test_done, 0);
        check(pat_ready == 1'b0, "R1 pat_ready in reset", pat_ready, 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        check(pin_out == 1'b0, "R1 pin_out in reset", pin_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out == 1'b0, "R1 pin_out after release", pin_out, 0);
    endtask

    task automatic t_session(input int npat, input logic b, input int bad_k, input string tag);
        int base;
        int guard;
        logic [N-1:0] exp_w;
        logic [N-1:0] got_w;
        base = nbits;
        test_en = 1'b1;
        pin_in  = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            if (k >= N && (bad_k < 0 || k < bad_k + N))
                check(pin_out == (((k - N) >> 1) & 1), {tag, " R4 flush tail"},
                      pin_out, ((k - N) >> 1) & 1);
            check(pat_ready == 1'b0, {tag, " R4 no ready in flush"}, pat_ready, 0);
            pin_in = (((k >> 1) & 1) != 0) ^ (k == bad_k);
            @(posedge clk);
        end
        @(negedge clk);
        if (bad_k >= 0) begin
            check(chain_err == 1'b1, {tag, " R5 mismatch flagged"}, chain_err, 1);
            pat_valid = 1'b1;
            pat_data  = 8'h3C;
            pat_last  = 1'b1;
            for (int s = 0; s < 5; s++) begin
                check(!pat_ready && !rsp_valid && !test_done, {tag, " R5 halted"},
                      {pat_ready, rsp_valid, test_done}, 0);
                @(posedge clk);
                @(negedge clk);
            end
            pat_valid = 1'b0;
            test_en   = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(chain_err == 1'b1, {tag, " R5 sticky after exit"}, chain_err, 1);
            return;
        end
        check(chain_err == 1'b0, {tag, " R5 clean flush clears flag"}, chain_err, 0);
        pin_in = b;
        for (int i = 0; i < npat; i++) begin
            guard = 0;
            while (!pat_ready && guard < 4 * N) begin
                @(posedge clk);
                @(negedge clk);
                guard++;
            end
            if (i == 1) begin
                exp_w = model_nxt(pats[0], b);
                for (int s = 0; s < 3; s++) begin
                    check(pin_out == exp_w[0] && pat_ready, {tag, " R8 hold while waiting"},
                          pin_out, exp_w[0]);
                    @(posedge clk);
                    @(negedge clk);
                end
            end
            check(nbits - base == N * ((i > 0) ? i - 1 : 0), {tag, " R7 overlap count at accept"},
                  nbits - base, N * ((i > 0) ? i - 1 : 0));
            pat_valid = 1'b1;
            pat_data  = pats[i];
            pat_last  = (i == npat - 1);
            @(posedge clk);
            @(negedge clk);
            pat_valid = 1'b0;
            pat_last  = 1'b0;
        end
        guard = 0;
        while (!test_done && guard < 4 * N) begin
            @(posedge clk);
            @(negedge clk);
            guard++;
        end
        check(test_done == 1'b1, {tag, " R9 done raised"}, test_done, 1);
        check(nbits - base == N * npat, {tag, " R7 response bit count"}, nbits - base, N * npat);
        check(last_at == base + N * npat - 1, {tag, " R9 last strobe position"},
              last_at, base + N * npat - 1);
        for (int i = 0; i < npat; i++) begin
            exp_w = model_nxt(pats[i], b);
            for (int j = 0; j < N; j++) got_w[j] = rsp_bits[base + i * N + j];
            check(got_w == exp_w, {tag, " R6 R7 captured response"}, got_w, exp_w);
        end
        @(posedge clk);
        @(negedge clk);
        check(test_done == 1'b1, {tag, " R9 done held"}, test_done, 1);
        test_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(test_done == 1'b0, {tag, " R9 done drops"}, test_done, 0);
        t_normal(6, '0, {tag, " R10 functional after session"});
    endtask

    initial begin
        t_reset();
        t_normal(12, '0, "R2 functional parity");
        pats[0] = 8'hA5; pats[1] = 8'hFF; pats[2] = 8'h00;
        t_session(3, 1'b1, -1, "S1");
        t_session(0, 1'b0, 2, "S2");
        pats[0] = 8'h80;
        t_session(1, 1'b0, -1, "S3");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule